// File: doc/BRIEF.md
# Triggered Hit Event Memory

This block is the digital back end of a multi-channel threshold detector chip. Each channel provides three comparator outputs, one for each of a low, a middle and a high threshold. The block first passes these asynchronous levels through a synchroniser. It then reduces each channel's three levels to a 2-bit energy code.

On every accepted trigger, the block writes the codes of all channels into an eight-entry event memory. The entry also holds the current value of a free-running bunch-crossing counter, which acts as a timestamp.

The block forwards each trigger one cycle later. It reports the number of stored events and flags when the memory is full. It records a sticky overflow when a trigger is lost. It also pulses a carry output once per crossing-counter period. A valid/ready port drains the stored events oldest first.

Top module: `hit_event_store`

## Requirements
- R1: While reset is held, evt_count is 0 and full, overflow, rd_valid, trig_out and carry_out are all 0.
- R2: Channel c's code sits at rd_codes[2c+1:2c]. With the low, middle and high comparator levels of channel c, the code is:
   - 3 (binary 11) when high is set;
   - otherwise 2 when middle is set;
   - otherwise 1 when low is set;
   - otherwise 0.
   This covers non-thermometer patterns: high alone gives 3, and middle alone gives 2.
- R3: A comparator change applied between two rising edges is stored only by triggers sampled on the third or a later rising edge after the change. Triggers on the first two of those edges store the previous levels.
- R4: The stored timestamp equals the number of rising edges since reset release, modulo 2^TS_W, counted up to the edge that samples the trigger.
- R5: carry_out is 1 exactly during the one cycle in which the crossing count equals 2^TS_W-1, the cycle just before it wraps to 0.
- R6: Events are read in the order they were accepted. evt_count rises by one for each accepted trigger and falls by one for each completed read.
- R7: full is 1 exactly when evt_count equals DEPTH (8 by default). A trigger seen while full is dropped: the count and the stored content are unchanged. The same trigger sets overflow, which stays 1 until reset.
- R8: trig_out is 1 in the cycle after each cycle in which trig_in is 1, whether or not that trigger is stored.
- R9: rd_valid is 1 exactly when evt_count is non-zero. While rd_valid is 1, rd_stamp and rd_codes show the oldest event. A read occurs on an edge where rd_valid and rd_ready are both 1. rd_ready while the memory is empty has no effect.
- R10: An accepted trigger and a read on the same edge leave evt_count unchanged. The written event becomes readable after the older ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_low | input | N_CH | Low-threshold comparator levels, one per channel |
| cmp_mid | input | N_CH | Middle-threshold comparator levels |
| cmp_high | input | N_CH | High-threshold comparator levels |
| trig_in | input | 1 | Trigger, sampled on each rising edge |
| trig_out | output | 1 | Trigger forwarded one cycle later |
| carry_out | output | 1 | One-cycle pulse before the crossing count wraps |
| full | output | 1 | Event memory holds DEPTH events |
| overflow | output | 1 | Sticky flag for a trigger lost while full |
| evt_count | output | $clog2(DEPTH+1) | Number of stored events |
| rd_valid | output | 1 | An event is available to read |
| rd_ready | input | 1 | Reader accepts the shown event |
| rd_stamp | output | TS_W | Timestamp of the oldest event |
| rd_codes | output | 2*N_CH | Packed 2-bit codes of the oldest event |

## Verification
A corrupted write or read pointer shows on the very next read. The returned timestamp no longer matches the edge count at which the bench fired that trigger, or the codes belong to another event.

A count that drifts shows within one cycle on evt_count and rd_valid. It then shows on full, which rises too early or too late while the memory is being filled to eight. A wrong synchroniser depth moves the R3 old/new boundary by one trigger.

A crossing counter that is off by any amount makes every stored timestamp wrong. It also moves the carry pulse away from the cycle the bench predicts from its own edge count.

// File: rtl/hes_pkg.sv
package hes_pkg;

   // Priority reduction of three threshold levels to a 2-bit energy code.
   function automatic logic [1:0] enc3(input logic lo, input logic mid, input logic hi);
      logic [1:0] r;
      if (hi)       r = 2'd3;
      else if (mid) r = 2'd2;
      else if (lo)  r = 2'd1;
      else          r = 2'd0;
      return r;
   endfunction

endpackage

// File: rtl/hes_sync.sv
module hes_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hes_encoder.sv
module hes_encoder #(
   parameter int N_CH = 64
) (
   input  logic [N_CH-1:0]   lo,
   input  logic [N_CH-1:0]   mid,
   input  logic [N_CH-1:0]   hi,
   output logic [2*N_CH-1:0] codes
);
   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         assign codes[2*c +: 2] = hes_pkg::enc3(lo[c], mid[c], hi[c]);
      end
   endgenerate
endmodule

// File: rtl/hes_xcount.sv
module hes_xcount #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count,
   output logic         carry
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;

   assign carry = &count;
endmodule

// File: rtl/hes_evfifo.sv
module hes_evfifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_ready,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          full
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_wr, do_rd;

   assign full     = (count == CW'(DEPTH));
   assign rd_valid = (count != '0);
   assign do_wr    = wr_req & ~full;
   assign do_rd    = rd_ready & rd_valid;
   assign rd_data  = mem[rptr];

   always_ff @(posedge clk)
      if (do_wr) mem[wptr] <= wr_data;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         count <= count + CW'(do_wr) - CW'(do_rd);
      end
endmodule

// File: rtl/hit_event_store.sv
module hit_event_store #(
   parameter int N_CH        = 64,
   parameter int TS_W        = 12,
   parameter int DEPTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_CH-1:0]              cmp_low,
   input  logic [N_CH-1:0]              cmp_mid,
   input  logic [N_CH-1:0]              cmp_high,
   input  logic                         trig_in,
   output logic                         trig_out,
   output logic                         carry_out,
   output logic                         full,
   output logic                         overflow,
   output logic [$clog2(DEPTH+1)-1:0]   evt_count,
   output logic                         rd_valid,
   input  logic                         rd_ready,
   output logic [TS_W-1:0]              rd_stamp,
   output logic [2*N_CH-1:0]            rd_codes
);
   localparam int CODE_W = 2 * N_CH;
   localparam int DW     = CODE_W + TS_W;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (TS_W < 2 || N_CH < 1) begin : g_bad_width
         $error("TS_W must be at least 2 and N_CH at least 1");
      end
   endgenerate

   logic [3*N_CH-1:0] lvl_s;
   logic [CODE_W-1:0] codes;
   logic [TS_W-1:0]   xcount;
   logic [DW-1:0]     rd_word;

   hes_sync #(.W(3*N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({cmp_high, cmp_mid, cmp_low}), .q(lvl_s));

   hes_encoder #(.N_CH(N_CH)) u_enc (
      .lo(lvl_s[0 +: N_CH]), .mid(lvl_s[N_CH +: N_CH]),
      .hi(lvl_s[2*N_CH +: N_CH]), .codes(codes));

   hes_xcount #(.W(TS_W)) u_xcnt (
      .clk(clk), .rst_n(rst_n), .count(xcount), .carry(carry_out));

   hes_evfifo #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_req(trig_in), .wr_data({xcount, codes}),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_word),
      .count(evt_count), .full(full));

   assign rd_stamp = rd_word[CODE_W +: TS_W];
   assign rd_codes = rd_word[0 +: CODE_W];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         trig_out <= 1'b0;
         overflow <= 1'b0;
      end else begin
         trig_out <= trig_in;
         if (trig_in && full) overflow <= 1'b1;
      end
endmodule

// File: rtl/hes_checker.sv
module hes_checker #(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trig_in,
   input logic          trig_out,
   input logic          full,
   input logic          overflow,
   input logic [CW-1:0] evt_count,
   input logic          rd_valid,
   input logic          rd_ready
);
   a_r8_trig_forward: assert property (@(posedge clk) disable iff (!rst_n)
      trig_in |=> trig_out);
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_in |=> !trig_out);
   a_r7_full_at_depth: assert property (@(posedge clk) disable iff (!rst_n)
      full == (evt_count == CW'(DEPTH)));
   a_r7_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_in && full) |=> overflow);
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   a_r7_count_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_ready) |=> (evt_count == CW'(DEPTH)));
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (evt_count == $past(evt_count)) ||
               (evt_count == $past(evt_count) + 1'b1) ||
               (evt_count == $past(evt_count) - 1'b1));
   a_r9_valid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == (evt_count != '0));
   a_r9_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid && !trig_in) |=> (evt_count == '0));
   a_r10_rdwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_in && !full && rd_valid && rd_ready) |=> $stable(evt_count));
endmodule

bind hit_event_store hes_checker #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
   .full(full), .overflow(overflow), .evt_count(evt_count),
   .rd_valid(rd_valid), .rd_ready(rd_ready));

// File: tb/hit_event_store_test.sv
`timescale 1ns/1ps
module hit_event_store_test;
   localparam int N_CH  = 64;
   localparam int TS_W  = 12;
   localparam int DEPTH = 8;
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int DW    = 2 * N_CH + TS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_CH-1:0] cmp_low = '0, cmp_mid = '0, cmp_high = '0;
   logic trig_in = 1'b0, rd_ready = 1'b0;
   logic trig_out, carry_out, full, overflow, rd_valid;
   logic [CW-1:0] evt_count;
   logic [TS_W-1:0] rd_stamp;
   logic [2*N_CH-1:0] rd_codes;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [TS_W-1:0] cyc;
   logic [DW-1:0] expq[$];

   always #2.5 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= '0;
      else        cyc <= cyc + 1'b1;

   hit_event_store #(.N_CH(N_CH), .TS_W(TS_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .cmp_low(cmp_low), .cmp_mid(cmp_mid),
      .cmp_high(cmp_high), .trig_in(trig_in), .trig_out(trig_out),
      .carry_out(carry_out), .full(full), .overflow(overflow),
      .evt_count(evt_count), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_stamp(rd_stamp), .rd_codes(rd_codes));

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Pattern selector per channel: 0 none,1 low,2 low+mid,3 all,4 high only,5 mid only
   task automatic apply_pattern(input int seed, output logic [2*N_CH-1:0] exp);
      for (int c = 0; c < N_CH; c++) begin
         int sel = (c + seed * 7) % 6;
         cmp_low[c]  = (sel == 1 || sel == 2 || sel == 3);
         cmp_mid[c]  = (sel == 2 || sel == 3 || sel == 5);
         cmp_high[c] = (sel == 3 || sel == 4);
         case (sel)
            0: exp[2*c +: 2] = 2'd0;
            1: exp[2*c +: 2] = 2'd1;
            2: exp[2*c +: 2] = 2'd2;
            5: exp[2*c +: 2] = 2'd2;
            default: exp[2*c +: 2] = 2'd3;
         endcase
      end
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire(input logic [2*N_CH-1:0] exp_codes, input bit accept);
      trig_in = 1'b1;
      if (accept) expq.push_back({cyc, exp_codes});
      @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic pop_check(input string req);
      logic [DW-1:0] e;
      chk(req, "rd_valid", DW'(rd_valid), DW'(1));
      e = expq.pop_front();
      chk(req, "rd_stamp", DW'(rd_stamp), DW'(e[2*N_CH +: TS_W]));
      chk(req, "rd_codes", DW'(rd_codes), DW'(e[0 +: 2*N_CH]));
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "evt_count", DW'(evt_count), '0);
      chk("R1", "flags", DW'({full, overflow, rd_valid, trig_out, carry_out}), '0);
   endtask

   task automatic t_encode;
      logic [2*N_CH-1:0] e;
      for (int s = 0; s < 6; s++) begin
         apply_pattern(s, e);
         wait_cycles(3);
         fire(e, 1);
         chk("R6", "count after trigger", DW'(evt_count), DW'(1));
         pop_check("R2 R4");
         chk("R9", "rd_valid empty", DW'(rd_valid), '0);
      end
   endtask

   task automatic t_sync;
      logic [2*N_CH-1:0] e_old, e_new;
      apply_pattern(0, e_old);
      wait_cycles(3);
      apply_pattern(1, e_new);
      trig_in = 1'b1;
      expq.push_back({cyc, e_old});
      @(negedge clk);
      chk("R8", "trig_out", DW'(trig_out), DW'(1));
      expq.push_back({cyc, e_old});
      @(negedge clk);
      expq.push_back({cyc, e_new});
      @(negedge clk);
      trig_in = 1'b0;
      chk("R6", "count 3", DW'(evt_count), DW'(3));
      @(negedge clk);
      chk("R8", "trig_out low", DW'(trig_out), '0);
      pop_check("R3 first edge");
      pop_check("R3 second edge");
      pop_check("R3 third edge");
   endtask

   task automatic t_simul;
      logic [2*N_CH-1:0] a, b;
      apply_pattern(2, a);
      wait_cycles(3);
      fire(a, 1);
      apply_pattern(3, b);
      wait_cycles(3);
      chk("R10", "head before", DW'(rd_codes), DW'(a));
      trig_in = 1'b1;
      rd_ready = 1'b1;
      void'(expq.pop_front());
      expq.push_back({cyc, b});
      @(negedge clk);
      trig_in = 1'b0;
      rd_ready = 1'b0;
      chk("R10", "count held", DW'(evt_count), DW'(1));
      pop_check("R10");
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      chk("R9", "empty read ignored", DW'(evt_count), '0);
   endtask

   task automatic t_carry;
      while (cyc != {{(TS_W-1){1'b1}}, 1'b0}) @(negedge clk);
      chk("R5", "carry before max", DW'(carry_out), '0);
      @(negedge clk);
      chk("R5", "carry at max", DW'(carry_out), DW'(1));
      @(negedge clk);
      chk("R5", "carry after wrap", DW'(carry_out), '0);
   endtask

   task automatic t_fill;
      logic [2*N_CH-1:0] e;
      for (int k = 0; k < DEPTH; k++) begin
         apply_pattern(k, e);
         wait_cycles(3);
         chk("R7", "full before", DW'(full), '0);
         fire(e, 1);
      end
      chk("R7", "full", DW'(full), DW'(1));
      chk("R7", "count depth", DW'(evt_count), DW'(DEPTH));
      chk("R7", "no overflow yet", DW'(overflow), '0);
      apply_pattern(9, e);
      wait_cycles(3);
      fire(e, 0);
      chk("R7", "overflow set", DW'(overflow), DW'(1));
      chk("R7", "count unchanged", DW'(evt_count), DW'(DEPTH));
      chk("R8", "trig_out on drop", DW'(trig_out), DW'(1));
      for (int k = 0; k < DEPTH; k++) pop_check("R6 R7 order");
      chk("R9", "empty after drain", DW'(rd_valid), '0);
      chk("R7", "overflow sticky", DW'(overflow), DW'(1));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_encode();
      t_sync();
      t_simul();
      t_carry();
      t_fill();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule